// File: doc/BRIEF.md
# Windowed Watchdog Monitor with Keyed Service

This block watches software health through a window. Once software enables it, a counter advances on every clock. Software has to service the monitor while the count lies between a lower and an upper compare value. A service is two key bytes written to a service register within a bounded number of cycles of each other. A valid service inside the window restarts the count at zero.

An early service, a malformed or late key pair, or a count that runs past the upper bound drives an active-low alarm pin. The alarm also fires when an external input pin reaches its selected asserted level, provided that input is enabled. The alarm latches until reset, and an interrupt request follows it when interrupts are enabled.

Access is through a single-cycle byte register bus with four registers. Address 0 is control, address 1 is the service register, address 2 is the lower compare and address 3 is the upper compare. Reads are combinational on the address.

Top module: `wdog_window_mon`

## Requirements
- R1: After reset, control reads 0x00, lower compare reads 0x00, upper compare reads 0xFF, `alarm_no` is 1 and `irq_o` is 0.
- R2: Control bit 0 is enable, bit 1 is input polarity, bit 2 is input enable and bit 3 is interrupt enable. Bits 7:4 always read 0, and the service register always reads 0x00.
- R3: Only the first control write after reset can change the enable bit. If that write leaves enable at 0, the monitor stays disabled and never alarms until reset. Later writes still update bits 3:1.
- R4: Setting enable clears the counter to 0. The counter then increments every clock and saturates at 0xFF. Once the count exceeds the upper compare, `alarm_no` falls on the following clock.
- R5: A valid key pair (0xB4, then 0x2C) whose second byte lands while the count is at or above the lower compare clears the counter to 0.
- R6: A valid key pair whose second byte lands while the count is below the lower compare asserts the alarm.
- R7: A first byte other than 0xB4, or a second byte other than 0x2C, asserts the alarm.
- R8: The second byte is accepted up to SERV_TIME (256) clocks after the first. At SERV_TIME+1 clocks or later, the service is illegal and the alarm asserts.
- R9: A write to any other register between the two key bytes aborts the sequence and asserts the alarm.
- R10: The external input is sampled through a 2-stage synchronizer. With input enable set, it asserts the alarm when the synchronized level equals the polarity bit, where 0 means active-low. With input enable clear, the input has no effect.
- R11: `irq_o` is high exactly while the alarm is asserted and interrupt enable is set. Writing 0 to interrupt enable drops it.
- R12: Once asserted, the alarm stays asserted until reset, including after a later valid service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| ext_i | input | 1 | External fault input |
| alarm_no | output | 1 | Alarm, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench probes both edges of the key window. A second byte at exactly 256 clocks must pass and one at 257 must fail, so an off-by-one timer shows up either as a spurious alarm or as a missed alarm. The lower compare is tested with the count one below it and at it, which catches a `>` used in place of `>=`. Overrun timing is checked on the exact clock, both with and without an intervening service: a counter that fails to clear, or that alarms one cycle early or late, gives the wrong pin level at the sampled point. Further tests cover lock-out of the enable bit, the external-input polarity and gating, and alarm stickiness after a later good service.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_SERV = 2'd1,
    A_CMPL = 2'd2,
    A_CMPH = 2'd3
  } reg_addr_e;

  localparam logic [REG_W-1:0] KEY_FIRST  = 8'hB4;
  localparam logic [REG_W-1:0] KEY_SECOND = 8'h2C;

  typedef struct packed {
    logic irq_en;
    logic in_en;
    logic pol;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[i] <= RST_VAL;
        else if (i == 0) pipe_q[i] <= d_i;
        else pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
#(
  parameter int SERV_TIME = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             serv_wr_i,
  input  logic             other_wr_i,
  input  logic [REG_W-1:0] data_i,
  output logic             ok_o,
  output logic             bad_o
);
  localparam int TW = $clog2(SERV_TIME + 1);
  localparam logic [TW-1:0] T_LAST = TW'(SERV_TIME - 1);

  logic          armed_q, armed_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    armed_d = armed_q;
    tmr_d   = tmr_q;
    ok_o    = 1'b0;
    bad_o   = 1'b0;
    if (!act_i) begin
      armed_d = 1'b0;
      tmr_d   = '0;
    end else if (!armed_q) begin
      if (serv_wr_i) begin
        if (data_i == KEY_FIRST) begin
          armed_d = 1'b1;
          tmr_d   = '0;
        end else begin
          bad_o = 1'b1;
        end
      end
    end else begin
      if (serv_wr_i) begin
        armed_d = 1'b0;
        if (data_i == KEY_SECOND) ok_o = 1'b1;
        else bad_o = 1'b1;
      end else if (other_wr_i) begin
        armed_d = 1'b0;
        bad_o   = 1'b1;
      end else if (tmr_q == T_LAST) begin
        // window closes: any later second byte is too late
        armed_d = 1'b0;
        bad_o   = 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      armed_q <= armed_d;
      tmr_q   <= tmr_d;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (run_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wdog_window_mon.sv
module wdog_window_mon
  import wdog_pkg::*;
#(
  parameter int               SERV_TIME   = 256,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] CMPH_RST    = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             ext_i,
  output logic             alarm_no,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic             lock_q;
  logic [REG_W-1:0] cmp_lo_q, cmp_hi_q;
  logic [REG_W-1:0] cnt_q;
  logic             alarm_q;

  logic wr_ctrl, wr_serv, wr_cmpl, wr_cmph;
  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_serv = wr_i && (addr_i == A_SERV);
  assign wr_cmpl = wr_i && (addr_i == A_CMPL);
  assign wr_cmph = wr_i && (addr_i == A_CMPH);

  logic en_w;
  assign en_w = ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      lock_q   <= 1'b0;
      cmp_lo_q <= '0;
      cmp_hi_q <= CMPH_RST;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.irq_en <= wdata_i[3];
        ctrl_q.in_en  <= wdata_i[2];
        ctrl_q.pol    <= wdata_i[1];
        if (!lock_q) begin
          ctrl_q.en <= wdata_i[0];
          lock_q    <= 1'b1;
        end
      end
      if (wr_cmpl) cmp_lo_q <= wdata_i;
      if (wr_cmph) cmp_hi_q <= wdata_i;
    end
  end

  logic ext_sync;
  wdog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_i),
    .q_o   (ext_sync)
  );

  logic ext_hit;
  assign ext_hit = en_w && ctrl_q.in_en && (ext_sync == ctrl_q.pol);

  logic key_ok, key_bad;
  wdog_key_seq #(.SERV_TIME(SERV_TIME)) u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (en_w),
    .serv_wr_i (wr_serv),
    .other_wr_i(wr_ctrl | wr_cmpl | wr_cmph),
    .data_i    (wdata_i),
    .ok_o      (key_ok),
    .bad_o     (key_bad)
  );

  logic en_set, early, in_win, overrun;
  assign en_set  = wr_ctrl && !lock_q && wdata_i[0];
  assign early   = key_ok && (cnt_q < cmp_lo_q);
  assign in_win  = key_ok && !early;
  assign overrun = en_w && (cnt_q > cmp_hi_q);

  wdog_counter #(.W(REG_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (en_set | in_win),
    .run_i (en_w),
    .cnt_o (cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else if (overrun || ext_hit || key_bad || early) alarm_q <= 1'b1;
  end

  assign alarm_no = ~alarm_q;
  assign irq_o    = alarm_q & ctrl_q.irq_en;

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {4'b0, ctrl_q};
      A_SERV:  rdata_o = '0;
      A_CMPL:  rdata_o = cmp_lo_q;
      default: rdata_o = cmp_hi_q;
    endcase
  end
endmodule

// File: rtl/wdog_window_mon_chk.sv
module wdog_window_mon_chk
  import wdog_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       addr_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             alarm_no,
  input logic             irq_o,
  input logic             en_w,
  input logic [REG_W-1:0] cnt_q,
  input logic [REG_W-1:0] cmp_hi_q,
  input logic             ext_hit,
  input logic             key_bad
);
  assert_alarm_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_no |=> !alarm_no);

  assert_irq_needs_alarm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !alarm_no);

  assert_ctrl_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> (rdata_o[7:4] == 4'h0));

  assert_serv_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SERV) |-> (rdata_o == '0));

  assert_en_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_w |=> en_w);

  assert_cnt_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_w) |-> (cnt_q == '0));

  assert_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && cnt_q > cmp_hi_q) |=> !alarm_no);

  assert_ext_alarm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_hit |=> !alarm_no);

  assert_bad_key_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_bad |=> !alarm_no);
endmodule

bind wdog_window_mon wdog_window_mon_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .alarm_no(alarm_no),
  .irq_o   (irq_o),
  .en_w    (en_w),
  .cnt_q   (cnt_q),
  .cmp_hi_q(cmp_hi_q),
  .ext_hit (ext_hit),
  .key_bad (key_bad)
);

// File: tb/sim_wdog_window_mon.sv
`timescale 1ns/1ps
module sim_wdog_window_mon;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       ext_i = 1'b1;
  logic       alarm_no;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  wdog_window_mon u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_i(ext_i),
    .alarm_no(alarm_no), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  lo;
    logic [15:0] pre;
    logic [7:0]  k1;
    logic [15:0] gap;
    logic [7:0]  k2;
    logic        exp_alarm;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'd0,  16'd5,  8'hB4, 16'd1,   8'h2C, 1'b0},  // R5 in window
    '{8'd0,  16'd5,  8'hB4, 16'd256, 8'h2C, 1'b0},  // R8 last legal cycle
    '{8'd0,  16'd5,  8'hB4, 16'd257, 8'h2C, 1'b1},  // R8 one late
    '{8'd0,  16'd5,  8'hB5, 16'd1,   8'h2C, 1'b1},  // R7 bad first
    '{8'd0,  16'd5,  8'hB4, 16'd1,   8'h2D, 1'b1},  // R7 bad second
    '{8'd0,  16'd5,  8'h2C, 16'd1,   8'hB4, 1'b1},  // R7 swapped
    '{8'd50, 16'd48, 8'hB4, 16'd1,   8'h2C, 1'b1},  // R6 count 49
    '{8'd50, 16'd49, 8'hB4, 16'd1,   8'h2C, 1'b0},  // R6 count 50
    '{8'd0,  16'd0,  8'hB4, 16'd10,  8'h2C, 1'b0}   // R5 immediate
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic do_reset(input logic ext_lvl);
    rst_ni = 1'b0; wr_i = 1'b0; ext_i = ext_lvl;
    idle(2);
    rst_ni = 1'b1;
    idle(3);
  endtask

  logic [7:0] r;

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset(1'b1);
    // R1 reset state
    rd(2'd0, r); check("R1 ctrl", r, 8'h00);
    rd(2'd2, r); check("R1 cmpl", r, 8'h00);
    rd(2'd3, r); check("R1 cmph", r, 8'hFF);
    check("R1 alarm_no", {7'd0, alarm_no}, 8'h01);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rd(2'd1, r); check("R2 serv reads 0", r, 8'h00);

    // key-window vector table
    for (int i = 0; i < NV; i++) begin
      do_reset(1'b1);
      wr(2'd2, VEC[i].lo);
      wr(2'd0, 8'h01);
      idle(int'(VEC[i].pre));
      wr(2'd1, VEC[i].k1);
      idle(int'(VEC[i].gap) - 1);
      wr(2'd1, VEC[i].k2);
      idle(2);
      check($sformatf("R5/R6/R7/R8 vec%0d", i), {7'd0, alarm_no}, {7'd0, !VEC[i].exp_alarm});
    end

    // R2/R3: first write clears enable, lock holds it off
    do_reset(1'b1);
    wr(2'd0, 8'hF6);
    rd(2'd0, r); check("R2 rsvd bits", r, 8'h06);
    wr(2'd0, 8'h05);
    rd(2'd0, r); check("R3 enable locked off", r, 8'h04);
    ext_i = 1'b0;
    idle(10);
    check("R3 disabled no alarm", {7'd0, alarm_no}, 8'h01);

    // R3: enable locked on
    do_reset(1'b1);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h08);
    rd(2'd0, r); check("R3 enable locked on", r, 8'h09);

    // R4 overrun timing, upper bound 20
    do_reset(1'b1);
    wr(2'd3, 8'd20);
    wr(2'd0, 8'h01);
    idle(21);
    check("R4 before overrun", {7'd0, alarm_no}, 8'h01);
    idle(1);
    check("R4 overrun", {7'd0, alarm_no}, 8'h00);

    // R5 service restarts the count
    do_reset(1'b1);
    wr(2'd3, 8'd20);
    wr(2'd0, 8'h01);
    idle(9);
    wr(2'd1, 8'hB4);
    wr(2'd1, 8'h2C);
    idle(21);
    check("R5 cleared count", {7'd0, alarm_no}, 8'h01);
    idle(1);
    check("R5 overrun after restart", {7'd0, alarm_no}, 8'h00);

    // R9 aborted sequence
    do_reset(1'b1);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hB4);
    wr(2'd2, 8'h00);
    idle(2);
    check("R9 abort", {7'd0, alarm_no}, 8'h00);

    // R10 input disabled
    do_reset(1'b1);
    wr(2'd0, 8'h01);
    ext_i = 1'b0;
    idle(6);
    check("R10 input gated", {7'd0, alarm_no}, 8'h01);

    // R10 active-low polarity with latency
    do_reset(1'b1);
    wr(2'd0, 8'h05);
    idle(5);
    check("R10 idle high", {7'd0, alarm_no}, 8'h01);
    ext_i = 1'b0;
    idle(2);
    check("R10 sync latency", {7'd0, alarm_no}, 8'h01);
    idle(1);
    check("R10 active-low hit", {7'd0, alarm_no}, 8'h00);

    // R10 active-high polarity
    do_reset(1'b0);
    wr(2'd0, 8'h07);
    idle(5);
    check("R10 high pol idle", {7'd0, alarm_no}, 8'h01);
    ext_i = 1'b1;
    idle(3);
    check("R10 high pol hit", {7'd0, alarm_no}, 8'h00);

    // R11 interrupt follows enable, R12 sticky
    check("R11 irq masked", {7'd0, irq_o}, 8'h00);
    wr(2'd0, 8'h0F);
    check("R11 irq on", {7'd0, irq_o}, 8'h01);
    wr(2'd0, 8'h07);
    check("R11 irq off", {7'd0, irq_o}, 8'h00);
    ext_i = 1'b0;
    idle(4);
    wr(2'd1, 8'hB4);
    wr(2'd1, 8'h2C);
    idle(3);
    check("R12 sticky", {7'd0, alarm_no}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule